// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns external pin activity into interrupt requests for a small microcontroller. Two dedicated inputs each have their own sense mode: low level, falling edge or rising edge. Twenty-four general pins are split into three pin-change banks. Each bank raises one request when any pin selected by its mask toggles. Every source has a sticky flag and an enable bit. A request is raised only when both are set. The exception is low-level sensing, which is not latched and follows the pin.

The I/O clock can be halted. This is modelled by the `io_clk_en` input: while it is low, the synchronizers and all clocked edge and toggle detection are frozen. Two kinds of activity still assert the combinational `wake` output while the clock is halted: a low level on an enabled dedicated input in low-level mode, and a masked pin in an enabled bank that differs from its last sampled value.

After a halt, low-level requests stay suppressed until the `startup_done` strobe. This strobe stands in for the clock start-up timer. If the level goes away before the strobe, the part still wakes, but no request is produced.

A small register port covers four things: the sense modes, the enable bits, the bank masks and the write-one-to-clear flags. Flags also clear on a per-source acknowledge. The pins are sampled only as levels, so a pin that the chip itself drives can trigger a software interrupt.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, `irq_req` and `wake` are 0 and every register reads 0.
- R2: In falling-edge mode (sense code 01), a 1-to-0 change on a dedicated input sets its flag, visible within four clocks. Its request follows while the input is enabled.
- R3: In rising-edge mode (sense code 10), a 0-to-1 change on a dedicated input sets its flag, visible within four clocks. Its request follows while the input is enabled.
- R4: In low-level mode (sense code 00), an enabled dedicated input requests for as long as its synchronized pin is low. It latches no flag, and its flag bit reads 0.
- R5: While `io_clk_en` is 0, no flag is set. A pulse on a dedicated input that starts and ends during the halt leaves no flag.
- R6: While `io_clk_en` is 0, an enabled dedicated input in low-level mode with its pin low asserts `wake` combinationally.
- R7: A bank flag is set when a pin that is both present and masked in that bank toggles. Bank 0 covers pins 7..0, bank 1 covers pins 14..8 and bank 2 covers pins 23..16. Unmasked pins, and pin 15, have no effect.
- R8: While `io_clk_en` is 0, a masked pin of an enabled bank that differs from its last sampled value asserts `wake`. On resume, the bank flag is set.
- R9: Flags are set whatever the enable bits say. `irq_req[i]` for an edge or bank source equals flag AND enable. Bit order: 0 = input 0, 1 = input 1, 2..4 = banks 0..2.
- R10: A flag clears when 1 is written to its bit at address 2, or when its `irq_ack` bit is pulsed.
- R11: After any cycle with `io_clk_en` at 0, low-level requests stay 0 until `startup_done` is seen. A level that is released before then produces no request.
- R12: The registers read back as follows. Address 0 holds the sense codes: input 0 in bits 1:0 and input 1 in bits 3:2. Address 1 holds the enables in bits 4:0. Address 2 holds the flags. Addresses 3 to 5 hold the masks for banks 0 to 2. Bit 7 of the bank 1 mask always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk_en | input | 1 | High while the I/O clock runs; low models a halt |
| startup_done | input | 1 | Strobe marking the end of clock start-up |
| ext_pin | input | 2 | Dedicated interrupt inputs |
| pc_pin | input | 24 | Pin-change inputs, three banks of eight |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 5 | Per-source acknowledge, clears the flag |
| irq_req | output | 5 | Per-source interrupt request |
| wake | output | 1 | Asynchronous wake while the I/O clock is halted |

## Verification
The assertions hold on every cycle for five properties:
- No request is raised without its enable bit.
- `wake` is raised only with some source enabled.
- No flag is set in a cycle after the I/O clock was halted.
- An acknowledge during a halt leaves the flag clear.
- Low-level requests stay silent through start-up, and no mask bit is set for an absent pin.

The bench scenarios are needed for the rest. A reference model compared on every clock covers the exact edge polarity and latency, and that a pulse made and undone during a halt is lost. The scenarios also show that a level released before the start-up strobe wakes the part yet never requests, and that unmasked pins and pin 15 are ignored.

// File: rtl/extint_pkg.sv
package extint_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_OFF  = 2'b11
    } sense_e;

    localparam int NUM_EXT  = 2;
    localparam int NUM_BANK = 3;
    localparam int BANK_W   = 8;
    localparam int NUM_PC   = NUM_BANK * BANK_W;
    localparam int NUM_SRC  = NUM_EXT + NUM_BANK;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK0 = 3'd3;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] old;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.s1  = din;
            st_d.s2  = st_q.s1;
            st_d.old = st_q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.old;
endmodule

// File: rtl/extint_sense.sv
module extint_sense
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clk_run,
    input  logic   pin_raw,
    input  logic   pin_cur,
    input  logic   pin_prev,
    input  sense_e mode,
    input  logic   enable,
    input  logic   clear,
    input  logic   startup_busy,
    output logic   flag,
    output logic   req,
    output logic   lvl_wake
);
    typedef struct packed {
        logic flag;
    } sense_st_t;

    sense_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            SENSE_FALL: hit = clk_run &  pin_prev & ~pin_cur;
            SENSE_RISE: hit = clk_run & ~pin_prev &  pin_cur;
            default:    hit = 1'b0;
        endcase
        st_d      = st_q;
        st_d.flag = hit | (st_q.flag & ~clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (mode == SENSE_LOW) req = enable & ~pin_cur & ~startup_busy;
        else                   req = enable & st_q.flag;
    end

    assign lvl_wake = (mode == SENSE_LOW) & enable & ~pin_raw;
    assign flag     = st_q.flag;
endmodule

// File: rtl/extint_pcbank.sv
module extint_pcbank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_run,
    input  logic [W-1:0] pin_raw,
    input  logic [W-1:0] pin_cur,
    input  logic [W-1:0] pin_prev,
    input  logic [W-1:0] mask,
    input  logic         enable,
    input  logic         clear,
    output logic         flag,
    output logic         req,
    output logic         wake
);
    typedef struct packed {
        logic flag;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     toggled;

    always_comb begin
        toggled   = clk_run & (|((pin_cur ^ pin_prev) & mask));
        st_d      = st_q;
        st_d.flag = toggled | (st_q.flag & ~clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign req  = enable & st_q.flag;
    assign wake = enable & (|((pin_raw ^ pin_prev) & mask));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter logic [NUM_PC-1:0] PC_IMPL = 24'hFF7FFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_clk_en,
    input  logic               startup_done,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_PC-1:0]  pc_pin,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] irq_ack,
    output logic [NUM_SRC-1:0] irq_req,
    output logic               wake
);
    localparam int MODE_W = 2 * NUM_EXT;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [NUM_SRC-1:0] en;
        logic [NUM_PC-1:0]  mask;
        logic               starting;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [NUM_SRC-1:0]  clr;
    logic [NUM_SRC-1:0]  flag_w;
    logic [NUM_EXT-1:0]  ext_cur, ext_prev, lvl_wake_w;
    logic [NUM_PC-1:0]   pc_cur, pc_prev;
    logic [NUM_BANK-1:0] pc_wake_w;
    logic [NUM_SRC-1:0]  en_w;
    logic [MODE_W-1:0]   mode_w;
    logic [NUM_PC-1:0]   mask_w;
    logic                starting_w;

    always_comb begin
        st_d = st_q;
        clr  = irq_ack;
        if (reg_we && reg_addr == A_FLAG) clr = clr | reg_wdata[NUM_SRC-1:0];
        if (reg_we) begin
            if (reg_addr == A_MODE) st_d.mode = reg_wdata[MODE_W-1:0];
            if (reg_addr == A_EN)   st_d.en   = reg_wdata[NUM_SRC-1:0];
            for (int b = 0; b < NUM_BANK; b++) begin
                if (reg_addr == A_MASK0 + ADDR_W'(b))
                    st_d.mask[b*BANK_W +: BANK_W] = reg_wdata & PC_IMPL[b*BANK_W +: BANK_W];
            end
        end
        if (!io_clk_en)        st_d.starting = 1'b1;
        else if (startup_done) st_d.starting = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_MODE) reg_rdata[MODE_W-1:0]  = st_q.mode;
        if (reg_addr == A_EN)   reg_rdata[NUM_SRC-1:0] = st_q.en;
        if (reg_addr == A_FLAG) reg_rdata[NUM_SRC-1:0] = flag_w;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (reg_addr == A_MASK0 + ADDR_W'(b))
                reg_rdata = st_q.mask[b*BANK_W +: BANK_W];
        end
    end

    extint_sync #(.W(NUM_EXT)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .adv(io_clk_en),
        .din(ext_pin), .cur(ext_cur), .prev(ext_prev)
    );

    extint_sync #(.W(NUM_PC)) u_pc_sync (
        .clk(clk), .rst_n(rst_n), .adv(io_clk_en),
        .din(pc_pin), .cur(pc_cur), .prev(pc_prev)
    );

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        extint_sense u_sense (
            .clk(clk),
            .rst_n(rst_n),
            .clk_run(io_clk_en),
            .pin_raw(ext_pin[i]),
            .pin_cur(ext_cur[i]),
            .pin_prev(ext_prev[i]),
            .mode(sense_e'(st_q.mode[2*i +: 2])),
            .enable(st_q.en[i]),
            .clear(clr[i]),
            .startup_busy(st_q.starting),
            .flag(flag_w[i]),
            .req(irq_req[i]),
            .lvl_wake(lvl_wake_w[i])
        );
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        extint_pcbank #(.W(BANK_W)) u_bank (
            .clk(clk),
            .rst_n(rst_n),
            .clk_run(io_clk_en),
            .pin_raw(pc_pin[b*BANK_W +: BANK_W]),
            .pin_cur(pc_cur[b*BANK_W +: BANK_W]),
            .pin_prev(pc_prev[b*BANK_W +: BANK_W]),
            .mask(st_q.mask[b*BANK_W +: BANK_W]),
            .enable(st_q.en[NUM_EXT+b]),
            .clear(clr[NUM_EXT+b]),
            .flag(flag_w[NUM_EXT+b]),
            .req(irq_req[NUM_EXT+b]),
            .wake(pc_wake_w[b])
        );
    end

    assign wake       = ~io_clk_en & ((|lvl_wake_w) | (|pc_wake_w));
    assign en_w       = st_q.en;
    assign mode_w     = st_q.mode;
    assign mask_w     = st_q.mask;
    assign starting_w = st_q.starting;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter logic [NUM_PC-1:0] PC_IMPL = 24'hFF7FFF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_clk_en,
    input logic [NUM_SRC-1:0] irq_ack,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               wake,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [2*NUM_EXT-1:0] mode_q,
    input logic               starting_q,
    input logic [NUM_PC-1:0]  mask_q
);
    a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~en_q) == '0);

    a_r8_wake_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (en_q != '0));

    a_r5_no_set_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !io_clk_en |=> ((flag_q & ~$past(flag_q)) == '0));

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[NUM_EXT] && !io_clk_en) |=> !flag_q[NUM_EXT]);

    a_r11_level_quiet_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (starting_q && mode_q[1:0] == 2'b00) |-> !irq_req[0]);

    a_r12_absent_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~PC_IMPL) == '0);
endmodule

bind extint_ctrl extint_ctrl_chk #(.PC_IMPL(PC_IMPL)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .io_clk_en(io_clk_en),
    .irq_ack(irq_ack),
    .irq_req(irq_req),
    .wake(wake),
    .en_q(en_w),
    .flag_q(flag_w),
    .mode_q(mode_w),
    .starting_q(starting_w),
    .mask_q(mask_w)
);

// File: tb/extint_ctrl_bench.sv
module extint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_clk_en = 1'b1;
    logic        startup_done = 1'b0;
    logic [1:0]  ext_pin = 2'b01;
    logic [23:0] pc_pin = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [4:0]  irq_ack = '0;
    logic [4:0]  irq_req;
    logic        wake;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    string cur_tag = "R1";

    extint_ctrl u_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .startup_done(startup_done),
        .ext_pin(ext_pin), .pc_pin(pc_pin), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .wake(wake)
    );

    always #4 clk = ~clk;

    // Reference model state
    int          m_mode[2];
    bit [4:0]    m_en;
    bit [23:0]   m_mask;
    bit [4:0]    m_flag;
    bit          m_start;
    bit [25:0]   m_pipe[$];

    function automatic bit [25:0] newest_sync();
        return m_pipe[1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '{0, 0}; m_en = '0; m_mask = '0; m_flag = '0; m_start = 0;
            m_pipe = '{26'd0, 26'd0, 26'd0};
        end else begin
            bit [4:0]  clr;
            bit [4:0]  hit;
            bit [25:0] cur, old;
            cur = m_pipe[1];
            old = m_pipe[2];
            clr = irq_ack;
            if (reg_we && reg_addr == 3'd2) clr |= reg_wdata[4:0];
            hit = '0;
            for (int i = 0; i < 2; i++) begin
                if (io_clk_en && m_mode[i] == 1 && old[i] && !cur[i]) hit[i] = 1;
                if (io_clk_en && m_mode[i] == 2 && !old[i] && cur[i]) hit[i] = 1;
            end
            for (int b = 0; b < 3; b++) begin
                bit [7:0] diff;
                diff = (cur[2+8*b +: 8] ^ old[2+8*b +: 8]) & m_mask[8*b +: 8];
                if (io_clk_en && diff != 0) hit[2+b] = 1;
            end
            m_flag = hit | (m_flag & ~clr);
            if (!io_clk_en) m_start = 1;
            else if (startup_done) m_start = 0;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: begin m_mode[0] = int'(reg_wdata[1:0]); m_mode[1] = int'(reg_wdata[3:2]); end
                    3'd1: m_en = reg_wdata[4:0];
                    3'd3: m_mask[7:0]   = reg_wdata;
                    3'd4: m_mask[15:8]  = reg_wdata & 8'h7F;
                    3'd5: m_mask[23:16] = reg_wdata;
                    default: ;
                endcase
            end
            if (io_clk_en) begin
                m_pipe.push_front({pc_pin, ext_pin});
                void'(m_pipe.pop_back());
            end
        end
    end

    function automatic bit [4:0] exp_req();
        bit [4:0]  r;
        bit [25:0] cur;
        cur = newest_sync();
        for (int i = 0; i < 2; i++)
            r[i] = (m_mode[i] == 0) ? (m_en[i] && !cur[i] && !m_start) : (m_en[i] && m_flag[i]);
        for (int b = 0; b < 3; b++) r[2+b] = m_en[2+b] && m_flag[2+b];
        return r;
    endfunction

    function automatic bit exp_wake();
        bit        w;
        bit [25:0] old;
        old = m_pipe[2];
        w = 0;
        for (int i = 0; i < 2; i++)
            if (m_mode[i] == 0 && m_en[i] && !ext_pin[i]) w = 1;
        for (int b = 0; b < 3; b++)
            if (m_en[2+b] && (((pc_pin[8*b +: 8] ^ old[2+8*b +: 8]) & m_mask[8*b +: 8]) != 0)) w = 1;
        return w && !io_clk_en;
    endfunction

    function automatic bit [7:0] exp_rdata();
        case (reg_addr)
            3'd0: return {4'd0, m_mode[1][1:0], m_mode[0][1:0]};
            3'd1: return {3'd0, m_en};
            3'd2: return {3'd0, m_flag};
            3'd3: return m_mask[7:0];
            3'd4: return m_mask[15:8];
            3'd5: return m_mask[23:16];
            default: return 8'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (irq_req !== exp_req()) begin
                n_err++;
                $display("FAIL %s model irq_req actual=%b expected=%b", cur_tag, irq_req, exp_req());
            end
            n_chk++;
            if (wake !== exp_wake()) begin
                n_err++;
                $display("FAIL %s model wake actual=%b expected=%b", cur_tag, wake, exp_wake());
            end
            n_chk++;
            if (reg_rdata !== exp_rdata()) begin
                n_err++;
                $display("FAIL %s model rdata actual=%h expected=%h", cur_tag, reg_rdata, exp_rdata());
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
        tick(1);
    endtask

    task automatic sample_chk(input string tag, input logic [31:0] act_sel, input logic [31:0] exp);
        chk(tag, act_sel, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        cur_tag = "R1";
        @(negedge clk);
        chk("R1 irq_req", {27'd0, irq_req}, 32'd0);
        chk("R1 wake", {31'd0, wake}, 32'd0);
        tick(1);
        for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 8'h00);

        // R12 register readback
        cur_tag = "R12";
        wr(3'd4, 8'hFF);
        rd_chk("R12 mask1 msb", 3'd4, 8'h7F);
        wr(3'd3, 8'hA5);
        rd_chk("R12 mask0", 3'd3, 8'hA5);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);

        // R2 falling edge
        cur_tag = "R2";
        wr(3'd0, 8'b1001);
        wr(3'd1, 8'b00011);
        ext_pin[0] = 1'b0;
        tick(4);
        @(negedge clk);
        chk("R2 fall req", {31'd0, irq_req[0]}, 32'd1);
        tick(1);
        rd_chk("R2 flag", 3'd2, 8'h01);

        // R10 write-one-to-clear
        cur_tag = "R10";
        wr(3'd2, 8'h01);
        @(negedge clk);
        chk("R10 w1c req", {31'd0, irq_req[0]}, 32'd0);
        tick(1);

        // R3 rising edge, then R10 acknowledge
        cur_tag = "R3";
        ext_pin[1] = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R3 rise req", {31'd0, irq_req[1]}, 32'd1);
        tick(1);
        cur_tag = "R10";
        irq_ack = 5'b00010;
        tick(1);
        irq_ack = '0;
        @(negedge clk);
        chk("R10 ack req", {31'd0, irq_req[1]}, 32'd0);
        tick(1);

        // R9 flag without enable
        cur_tag = "R9";
        ext_pin[0] = 1'b1;
        tick(4);
        wr(3'd1, 8'b00010);
        ext_pin[0] = 1'b0;
        tick(4);
        @(negedge clk);
        chk("R9 disabled req", {31'd0, irq_req[0]}, 32'd0);
        tick(1);
        rd_chk("R9 flag set", 3'd2, 8'h01);
        wr(3'd1, 8'b00011);
        @(negedge clk);
        chk("R9 enabled req", {31'd0, irq_req[0]}, 32'd1);
        tick(1);
        wr(3'd2, 8'h03);

        // R4 low level
        cur_tag = "R4";
        ext_pin[0] = 1'b1;
        wr(3'd0, 8'b1000);
        tick(4);
        ext_pin[0] = 1'b0;
        tick(4);
        @(negedge clk);
        chk("R4 low req", {31'd0, irq_req[0]}, 32'd1);
        tick(1);
        rd_chk("R4 no flag", 3'd2, 8'h00);
        ext_pin[0] = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R4 high no req", {31'd0, irq_req[0]}, 32'd0);
        tick(1);

        // R5 pulse during halt is lost
        cur_tag = "R5";
        wr(3'd0, 8'b1001);
        tick(2);
        io_clk_en = 1'b0;
        tick(1);
        ext_pin[0] = 1'b0;
        tick(2);
        ext_pin[0] = 1'b1;
        tick(2);
        io_clk_en = 1'b1;
        startup_done = 1'b1;
        tick(1);
        startup_done = 1'b0;
        tick(4);
        rd_chk("R5 no flag", 3'd2, 8'h00);

        // R6 level wake, R11 level released before start-up end
        cur_tag = "R6";
        wr(3'd0, 8'b1000);
        tick(4);
        io_clk_en = 1'b0;
        tick(1);
        ext_pin[0] = 1'b0;
        @(negedge clk);
        chk("R6 level wake", {31'd0, wake}, 32'd1);
        tick(1);
        cur_tag = "R11";
        io_clk_en = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R11 quiet in startup", {31'd0, irq_req[0]}, 32'd0);
        tick(1);
        ext_pin[0] = 1'b1;
        tick(3);
        startup_done = 1'b1;
        tick(1);
        startup_done = 1'b0;
        tick(3);
        @(negedge clk);
        chk("R11 released early", {31'd0, irq_req[0]}, 32'd0);
        tick(1);
        rd_chk("R11 no flag", 3'd2, 8'h00);

        // R11 level held through start-up
        io_clk_en = 1'b0;
        tick(1);
        ext_pin[0] = 1'b0;
        tick(2);
        io_clk_en = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R11 held before strobe", {31'd0, irq_req[0]}, 32'd0);
        tick(1);
        startup_done = 1'b1;
        tick(1);
        startup_done = 1'b0;
        tick(1);
        @(negedge clk);
        chk("R11 held after strobe", {31'd0, irq_req[0]}, 32'd1);
        tick(1);
        ext_pin[0] = 1'b1;
        tick(4);

        // R7 pin-change banks
        cur_tag = "R7";
        wr(3'd1, 8'b11100);
        wr(3'd3, 8'h04);
        pc_pin[2] = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R7 bank0 masked", {31'd0, irq_req[2]}, 32'd1);
        tick(1);
        wr(3'd2, 8'h04);
        pc_pin[3] = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R7 bank0 unmasked", {31'd0, irq_req[2]}, 32'd0);
        tick(1);
        wr(3'd4, 8'hFF);
        pc_pin[15] = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R7 pin15 absent", {31'd0, irq_req[3]}, 32'd0);
        tick(1);
        pc_pin[14] = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R7 bank1 pin14", {31'd0, irq_req[3]}, 32'd1);
        tick(1);
        cur_tag = "R10";
        irq_ack = 5'b01000;
        tick(1);
        irq_ack = '0;
        @(negedge clk);
        chk("R10 bank1 ack", {31'd0, irq_req[3]}, 32'd0);
        tick(1);

        // R8 pin-change wake while halted
        cur_tag = "R8";
        wr(3'd5, 8'h10);
        tick(2);
        io_clk_en = 1'b0;
        tick(1);
        pc_pin[20] = 1'b1;
        @(negedge clk);
        chk("R8 pc wake", {31'd0, wake}, 32'd1);
        chk("R8 no req halted", {31'd0, irq_req[4]}, 32'd0);
        tick(2);
        io_clk_en = 1'b1;
        startup_done = 1'b1;
        tick(1);
        startup_done = 1'b0;
        tick(4);
        @(negedge clk);
        chk("R8 flag on resume", {31'd0, irq_req[4]}, 32'd1);
        tick(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule